// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned W-bit operands and returns the full 2W-bit product. It is an array of full-adder rows in which every row is registered. A new operand pair can enter on every clock, and up to 2W-1 multiplications are in flight at once, one per row. The first W-1 rows are carry-save rows. Each one adds the next shifted partial product (multiplicand AND one multiplier bit) to the running sum and carry vectors, without sideways carry propagation.

A row settles the lowest still-open product bit once it has added its partial product. From that row on, the bit simply travels down the pipeline with its pair. The upper half is resolved by W-1 carry rows instead of a long adder. Each carry row settles exactly one bit position and passes a single carry one position up to the next row. A final registered stage settles the top bit.

The multiplicand and the multiplier bits are delayed alongside the data, so each row sees the operands of its own pair. The caller drives `in_valid` with an operand pair and receives `out_valid` with the product a fixed number of cycles later. The parameter W must be at least 3.

Top module: `csa_pipe_mult`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned product of the `in_a` and `in_b` values of the pair it belongs to, all 2W bits, with no truncation.
- R2: Latency is exactly 2W-1 register stages: a pair sampled on rising edge k appears on the outputs just after rising edge k+2W-2, and `out_valid` reproduces `in_valid` delayed by that amount.
- R3: A new pair is accepted on every cycle with `in_valid` high, including fully back-to-back streams, and results leave in arrival order with none lost or duplicated.
- R4: `rst` is synchronous and active high: every rising edge with `rst` high drops all pairs in flight, including the one offered on that edge. `out_valid` is low after such an edge, and none of the dropped pairs ever produces a result.
- R5: A cycle with `in_valid` low creates no result, whatever values `in_a` and `in_b` carry, so gaps in the input stream reappear unchanged at the output.
- R6: Extreme operands give exact results: a zero operand gives 0, one times all-ones gives all-ones in the low half, and all-ones times all-ones gives 2^(2W) - 2^(W+1) + 1, which exercises every carry row.
- R7: While `out_valid` is low (also during and after reset), `out_product` keeps the last delivered product unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset, clears all valid flags |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | W | Multiplicand, unsigned |
| in_b | input | W | Multiplier, unsigned |
| out_valid | output | 1 | `out_product` carries a new result this cycle |
| out_product | output | 2W | Registered unsigned product |

## Verification
The bound checker keeps its own delay line of offered pairs. On every cycle it checks that `out_valid` matches the delayed `in_valid`, that each valid product equals the delayed arithmetic product, that no result follows a reset edge, and that the product register does not move while no result is signalled. Only the bench's scenarios show the effects that depend on a chosen stimulus: the carry chain of all-ones operands, gaps filled with garbage operands, a reset dropping a pair offered on the reset edge itself, and the latency measured as a cycle count on a lone pair in an empty pipeline.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  // Carry-save rows: one for each multiplier bit after the first.
  function automatic int csa_rows(input int w);
    return w - 1;
  endfunction

  // Carry rows: one for each upper product bit below the top bit.
  function automatic int carry_rows(input int w);
    return w - 1;
  endfunction

  // Register stages from input sample to output register.
  function automatic int pipe_latency(input int w);
    return csa_rows(w) + carry_rows(w) + 1;
  endfunction

endpackage

// File: rtl/csa_mult_csa_row.sv
// One registered carry-save row. It adds partial product in_a & b[ROW]
// (weight 2^ROW) to the accumulated sum/carry pair. Carry bits are kept
// only for positions ROW..2W-1, since everything below is already settled.
module csa_mult_csa_row #(
  parameter int W   = 8,
  parameter int ROW = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_i,
  input  logic [W-1:0]          a_i,
  input  logic                  xbit_i,
  input  logic [2*W-1:0]        s_i,
  input  logic [2*W-1-ROW:0]    c_i,
  output logic                  v_o,
  output logic [2*W-1:0]        s_o,
  output logic [2*W-2-ROW:0]    c_o
);

  localparam int TW = 2 * W;
  localparam int CI = TW - ROW;
  localparam int CO = CI - 1;

  logic [CI-1:0] s_hi;
  logic [CI-1:0] p_hi;
  logic [CI-1:0] sum_hi;
  logic [CO-1:0] maj;
  logic [TW-1:0] s_nx;

  always_comb begin
    s_hi   = s_i[TW-1:ROW];
    p_hi   = {{(CI-W){1'b0}}, a_i & {W{xbit_i}}};
    sum_hi = s_hi ^ c_i ^ p_hi;
    maj    = (s_hi[CO-1:0] & c_i[CO-1:0])
           | (s_hi[CO-1:0] & p_hi[CO-1:0])
           | (c_i[CO-1:0]  & p_hi[CO-1:0]);
    s_nx   = {sum_hi, s_i[ROW-1:0]};
  end

  always_ff @(posedge clk) begin
    v_o <= rst ? 1'b0 : v_i;
    if (v_i && !rst) begin
      s_o <= s_nx;
      c_o <= maj;
    end
  end

endmodule

// File: rtl/csa_mult_carry_row.sv
// One registered carry row: settles product bit POS from the sum bit,
// the saved carry bit and the ripple carry of the row above, and hands a
// single carry one position up. Carry bits kept: positions POS..2W-1.
module csa_mult_carry_row #(
  parameter int W   = 8,
  parameter int POS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  v_i,
  input  logic [2*W-1:0]        s_i,
  input  logic [2*W-1-POS:0]    c_i,
  input  logic                  cy_i,
  output logic                  v_o,
  output logic [2*W-1:0]        s_o,
  output logic [2*W-2-POS:0]    c_o,
  output logic                  cy_o
);

  localparam int TW = 2 * W;
  localparam int CI = TW - POS;

  logic          bit_nx;
  logic          cy_nx;
  logic [TW-1:0] s_nx;

  always_comb begin
    bit_nx = s_i[POS] ^ c_i[0] ^ cy_i;
    cy_nx  = (s_i[POS] & c_i[0]) | (s_i[POS] & cy_i) | (c_i[0] & cy_i);
    s_nx   = {s_i[TW-1:POS+1], bit_nx, s_i[POS-1:0]};
  end

  always_ff @(posedge clk) begin
    v_o <= rst ? 1'b0 : v_i;
    if (v_i && !rst) begin
      s_o  <= s_nx;
      c_o  <= c_i[CI-1:1];
      cy_o <= cy_nx;
    end
  end

endmodule

// File: rtl/csa_pipe_mult.sv
module csa_pipe_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   in_a,
  input  logic [W-1:0]   in_b,
  output logic           out_valid,
  output logic [2*W-1:0] out_product
);

  import csa_mult_pkg::*;

  localparam int TW   = 2 * W;
  localparam int NCSA = csa_rows(W);
  localparam int NRES = carry_rows(W);

  // ---------------------------------------------------------------------
  // Multiplier bit j is consumed by row j, which registers j-1 edges after
  // the sample edge; bit j therefore rides a chain of j-1 flops.
  // ---------------------------------------------------------------------
  logic [W-1:0] xb;
  assign xb[0] = in_b[0];
  assign xb[1] = in_b[1];

  for (genvar j = 2; j < W; j++) begin : g_bdly
    logic [j-2:0] dl;
    if (j == 2) begin : g_one
      always_ff @(posedge clk) dl <= in_b[j];
    end else begin : g_many
      always_ff @(posedge clk) dl <= {dl[j-3:0], in_b[j]};
    end
    assign xb[j] = dl[j-2];
  end

  // Multiplicand delay: row k (k >= 2) reads a_q[k-2].
  logic [W-1:0] a_q [W-2];

  always_ff @(posedge clk) begin
    a_q[0] <= in_a;
    for (int i = 1; i < W - 2; i++) a_q[i] <= a_q[i-1];
  end

  // ---------------------------------------------------------------------
  // Carry-save rows 1..W-1
  // ---------------------------------------------------------------------
  for (genvar k = 1; k <= NCSA; k++) begin : g_csa
    logic            v_in;
    logic            v_out;
    logic [W-1:0]    a_in;
    logic [TW-1:0]   s_in;
    logic [TW-1:0]   s_out;
    logic [TW-1-k:0] c_in;
    logic [TW-2-k:0] c_out;

    if (k == 1) begin : g_head
      assign v_in = in_valid;
      assign a_in = in_a;
      assign s_in = {{W{1'b0}}, in_a & {W{xb[0]}}};
      assign c_in = '0;
    end else begin : g_body
      assign v_in = g_csa[k-1].v_out;
      assign a_in = a_q[k-2];
      assign s_in = g_csa[k-1].s_out;
      assign c_in = g_csa[k-1].c_out;
    end

    csa_mult_csa_row #(.W(W), .ROW(k)) u_row (
      .clk    (clk),
      .rst    (rst),
      .v_i    (v_in),
      .a_i    (a_in),
      .xbit_i (xb[k]),
      .s_i    (s_in),
      .c_i    (c_in),
      .v_o    (v_out),
      .s_o    (s_out),
      .c_o    (c_out)
    );
  end

  // ---------------------------------------------------------------------
  // Carry rows settling positions W..2W-2, one position per row
  // ---------------------------------------------------------------------
  for (genvar r = 0; r < NRES; r++) begin : g_res
    localparam int POS = W + r;
    logic              v_in;
    logic              v_out;
    logic              cy_in;
    logic              cy_out;
    logic [TW-1:0]     s_in;
    logic [TW-1:0]     s_out;
    logic [TW-1-POS:0] c_in;
    logic [TW-2-POS:0] c_out;

    if (r == 0) begin : g_head
      assign v_in  = g_csa[NCSA].v_out;
      assign s_in  = g_csa[NCSA].s_out;
      assign c_in  = g_csa[NCSA].c_out;
      assign cy_in = 1'b0;
    end else begin : g_body
      assign v_in  = g_res[r-1].v_out;
      assign s_in  = g_res[r-1].s_out;
      assign c_in  = g_res[r-1].c_out;
      assign cy_in = g_res[r-1].cy_out;
    end

    csa_mult_carry_row #(.W(W), .POS(POS)) u_row (
      .clk  (clk),
      .rst  (rst),
      .v_i  (v_in),
      .s_i  (s_in),
      .c_i  (c_in),
      .cy_i (cy_in),
      .v_o  (v_out),
      .s_o  (s_out),
      .c_o  (c_out),
      .cy_o (cy_out)
    );
  end

  // ---------------------------------------------------------------------
  // Output stage: settle the top bit and register the product
  // ---------------------------------------------------------------------
  logic          fin_v;
  logic [TW-1:0] fin_s;
  logic          fin_c;
  logic          fin_cy;

  assign fin_v  = g_res[NRES-1].v_out;
  assign fin_s  = g_res[NRES-1].s_out;
  assign fin_c  = g_res[NRES-1].c_out[0];
  assign fin_cy = g_res[NRES-1].cy_out;

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : fin_v;
    if (fin_v && !rst) begin
      out_product <= {fin_s[TW-1] ^ fin_c ^ fin_cy, fin_s[TW-2:0]};
    end
  end

endmodule

// File: rtl/csa_pipe_mult_chk.sv
module csa_pipe_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   in_a,
  input logic [W-1:0]   in_b,
  input logic           out_valid,
  input logic [2*W-1:0] out_product
);

  localparam int LAT = csa_mult_pkg::pipe_latency(W);
  localparam int TW  = 2 * W;

  // Independent delay line of offered pairs and their arithmetic products.
  logic [LAT-1:0] vpipe;
  logic [TW-1:0]  ppipe [LAT];

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
    ppipe[0] <= TW'(in_a) * TW'(in_b);
    for (int i = 1; i < LAT; i++) ppipe[i] <= ppipe[i-1];
  end

  // R2, R3, R5: valid output is the input valid delayed by the latency
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[LAT-1]);

  // R1: every delivered product matches its own pair
  a_r1_product: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_product == ppipe[LAT-1]));

  // R4: nothing is delivered right after a reset edge
  a_r4_flush: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R7: product register holds when no result is signalled
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_product));

endmodule

bind csa_pipe_mult csa_pipe_mult_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_product (out_product)
);

// File: tb/tb_csa_pipe_mult.sv
`timescale 1ns/1ps
module tb_csa_pipe_mult;

  localparam int W   = 8;
  localparam int TW  = 2 * W;
  localparam int LAT = 2 * W - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_a = '0;
  logic [W-1:0]  in_b = '0;
  logic          out_valid;
  logic [TW-1:0] out_product;

  int    checks   = 0;
  int    failures = 0;
  string phase    = "R4 reset";

  csa_pipe_mult #(.W(W)) dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_a        (in_a),
    .in_b        (in_b),
    .out_valid   (out_valid),
    .out_product (out_product)
  );

  always #2 clk = ~clk;

  // Behavioural reference: expected results per cycle in a delay line.
  logic          ev [LAT];
  logic [TW-1:0] ep [LAT];
  logic [TW-1:0] last_p = '0;
  bit            have_p = 1'b0;
  bit            started = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) ev[i] = 1'b0;
    end else begin
      for (int i = LAT - 1; i > 0; i--) begin
        ev[i] = ev[i-1];
        ep[i] = ep[i-1];
      end
      ev[0] = in_valid;
      ep[0] = TW'(in_a) * TW'(in_b);
      if (ev[LAT-1]) begin
        last_p = ep[LAT-1];
        have_p = 1'b1;
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (out_valid !== ev[LAT-1]) begin
        failures++;
        $display("FAIL R2 valid (%s): actual=%b expected=%b", phase, out_valid, ev[LAT-1]);
      end else if (ev[LAT-1] && out_product !== ep[LAT-1]) begin
        failures++;
        $display("FAIL R1 product (%s): actual=%0d expected=%0d", phase, out_product, ep[LAT-1]);
      end else if (!ev[LAT-1] && have_p && out_product !== last_p) begin
        failures++;
        $display("FAIL R7 hold (%s): actual=%0d expected=%0d", phase, out_product, last_p);
      end
    end
  end

  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic r);
    @(posedge clk);
    #1;
    in_valid = v;
    in_a     = a;
    in_b     = b;
    rst      = r;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL R3 watchdog: actual=running expected=finished");
    finish_up();
  end

  initial begin
    logic [W-1:0] ones;
    ones = '1;

    // R4: reset state
    for (int i = 0; i < 3; i++) step(1'b1, W'($urandom), W'($urandom), 1'b1);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R4 reset state: actual=%b expected=0", out_valid);
    end
    step(1'b0, '0, '0, 1'b0);

    // R2: latency of a lone pair in an empty pipeline
    phase = "R2 latency";
    for (int i = 0; i < LAT + 2; i++) step(1'b0, W'($urandom), W'($urandom), 1'b0);
    step(1'b1, 8'd13, 8'd11, 1'b0);
    begin
      int n;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      n = 1;
      while (n < 64) begin
        @(negedge clk);
        if (out_valid) break;
        @(posedge clk);
        n++;
      end
      checks++;
      if (n != LAT) begin
        failures++;
        $display("FAIL R2 latency: actual=%0d expected=%0d", n, LAT);
      end
    end

    // R6: extreme operands back to back
    phase = "R6 extremes";
    step(1'b1, '0, ones, 1'b0);
    step(1'b1, ones, '0, 1'b0);
    step(1'b1, ones, ones, 1'b0);
    step(1'b1, W'(1), ones, 1'b0);
    step(1'b1, ones, W'(1), 1'b0);
    step(1'b1, W'(1) << (W-1), W'(1) << (W-1), 1'b0);
    step(1'b1, ones, ones, 1'b0);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, W'($urandom), W'($urandom), 1'b0);
    checks++;
    if (out_product !== (TW'(1) - (TW'(1) << (W+1)) + TW'(1) + ((TW'(1) << TW) - TW'(1)))) begin
      // all-ones squared: 2^(2W) - 2^(W+1) + 1 (mod 2^(2W))
      failures++;
      $display("FAIL R6 all-ones: actual=%0d expected=%0d", out_product,
               TW'(1) - (TW'(1) << (W+1)) + TW'(1) + ((TW'(1) << TW) - TW'(1)));
    end

    // R3: back-to-back random stream
    phase = "R3 stream";
    for (int i = 0; i < 200; i++) step(1'b1, W'($urandom), W'($urandom), 1'b0);

    // R5: gaps with garbage operands
    phase = "R5 gaps";
    for (int i = 0; i < 150; i++) step(1'($urandom), W'($urandom), W'($urandom), 1'b0);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, W'($urandom), W'($urandom), 1'b0);

    // R4: reset in the middle of a stream, pair on the reset edge dropped
    phase = "R4 flush";
    for (int i = 0; i < 6; i++) step(1'b1, W'($urandom), W'($urandom), 1'b0);
    step(1'b1, W'($urandom), W'($urandom), 1'b1);
    step(1'b0, W'($urandom), W'($urandom), 1'b0);
    begin
      bit seen;
      seen = 1'b0;
      for (int i = 0; i < LAT + 2; i++) begin
        @(negedge clk);
        if (out_valid) seen = 1'b1;
      end
      checks++;
      if (seen) begin
        failures++;
        $display("FAIL R4 flushed pair delivered: actual=1 expected=0");
      end
    end

    // R7: hold after reset, then a final stream
    phase = "R7 hold";
    for (int i = 0; i < 40; i++) step(1'($urandom), W'($urandom), W'($urandom), 1'b0);
    for (int i = 0; i < LAT + 4; i++) step(1'b0, W'($urandom), W'($urandom), 1'b0);

    finish_up();
  end

endmodule